// File: doc/BRIEF.md
# Vectored Interrupt Pointer Fetch Unit

This unit turns an accepted interrupt into a program-counter load using two levels of indirection. Once a request is taken, it acknowledges the request and waits for the interrupting device to present one byte. It clears that byte's lowest bit and places an 8-bit page value above it. The result is a 16-bit pointer into a table of handler addresses.

The unit then reads the two bytes of the table entry through a simple memory read port and presents the resulting 16-bit handler address with a one-cycle load strobe toward the program counter. Because the lowest bit of the device byte is cleared, each entry occupies two bytes and one table page holds 128 distinct handlers. Software sets the page value through a write strobe. Saving the old program counter and choosing between competing devices are left to neighbouring logic.

Top module: `vec_irq_fetch`

## Requirements
- R1: While `rst_n` is low, `irq_ack`, `mem_req` and `pc_load` are all 0, and the page value is cleared to 0x00.
- R2: A request seen while the unit is idle raises `irq_ack` on the next cycle. `irq_ack` stays high until a cycle in which `dev_valid` is high, and that byte is taken.
- R3: The first read of a sequence uses the address {page, device byte with bit 0 cleared}, with the page in bits 15:8. Its data becomes bits 7:0 of the handler.
- R4: The second read uses the first read's address plus one, which has bit 0 set. Its data becomes bits 15:8 of the handler.
- R5: While `mem_req` is high and `mem_ready` is low, the unit keeps `mem_req` high and `mem_addr` unchanged. A read completes in the cycle where both are high.
- R6: The cycle after the second read completes, `pc_load` is high for exactly one cycle and `pc_value` holds the handler address {high byte, low byte}.
- R7: A request that arrives while a sequence is in progress is ignored, even if it is held high. After the `pc_load` cycle the unit is idle for at least one cycle, and only then can a new request be acknowledged.
- R8: `page_we` loads `page_wdata` into the page value on the next clock edge. The page is sampled when the device byte is taken, so a page write during the table reads does not alter that sequence's addresses. It does apply to later sequences.
- R9: `dev_valid` and `mem_ready` have no effect while the unit is idle: no acknowledge, read or load follows from them.
- R10: At most one of `irq_ack`, `mem_req` and `pc_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request |
| irq_ack | output | 1 | Acknowledge; device must present its byte |
| dev_valid | input | 1 | Device byte present on `dev_byte` |
| dev_byte | input | 8 | Data bus byte from the interrupting device |
| page_we | input | 1 | Page value write strobe |
| page_wdata | input | 8 | New page value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address, valid while `mem_req` is high |
| mem_ready | input | 1 | Read data valid; completes the current read |
| mem_rdata | input | 8 | Memory read data |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_value | output | 16 | Handler address to load |

## Verification
The assertions check several rules on every cycle: the exclusivity of the three output strobes, the held request and address during a memory stall, the single-cycle load pulse, and the step from the even low-byte address to the odd high-byte address. They also check that an acknowledge persists until the byte arrives and that no acknowledge follows a load directly. The bench scenarios are needed for the rest. Only they can show that the full handler value read from the table is correct, and that a page written in mid-sequence is used by the next interrupt but not the current one. They also cover requests held high through a sequence, which must yield exactly one acknowledge, and the page and byte corners at 0x00 and 0xFF.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACK     = 3'd1,
    ST_READ_LO = 3'd2,
    ST_READ_HI = 3'd3,
    ST_LOAD_PC = 3'd4
  } vif_state_e;
endpackage

// File: rtl/vif_page_reg.sv
module vif_page_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] page_q
);
  logic [BYTE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end
endmodule

// File: rtl/vif_ctrl.sv
module vif_ctrl
  import vif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic dev_valid,
  input  logic mem_ready,
  output logic irq_ack,
  output logic mem_req,
  output logic sel_hi,
  output logic cap_ptr,
  output logic cap_lo,
  output logic cap_hi,
  output logic pc_load
);
  vif_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (irq_req)   st_d = ST_ACK;
      ST_ACK:     if (dev_valid) st_d = ST_READ_LO;
      ST_READ_LO: if (mem_ready) st_d = ST_READ_HI;
      ST_READ_HI: if (mem_ready) st_d = ST_LOAD_PC;
      ST_LOAD_PC:                st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    irq_ack = (st_q == ST_ACK);
    cap_ptr = (st_q == ST_ACK) && dev_valid;
    mem_req = (st_q == ST_READ_LO) || (st_q == ST_READ_HI);
    sel_hi  = (st_q == ST_READ_HI);
    cap_lo  = (st_q == ST_READ_LO) && mem_ready;
    cap_hi  = (st_q == ST_READ_HI) && mem_ready;
    pc_load = (st_q == ST_LOAD_PC);
  end
endmodule

// File: rtl/vif_addr_path.sv
module vif_addr_path #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTE_W-1:0]   page_q,
  input  logic [BYTE_W-1:0]   dev_byte,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic                cap_ptr,
  input  logic [1:0]          lane_cap,
  input  logic                sel_hi,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [2*BYTE_W-1:0] handler
);
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int NUM_LANES = ADDR_W / BYTE_W;
  localparam logic [BYTE_W-1:0] ALIGN_MASK = ~BYTE_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (cap_ptr) ptr_d = {page_q, dev_byte & ALIGN_MASK};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign mem_addr = ptr_q | {{(ADDR_W-1){1'b0}}, sel_hi};

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;

    always_comb begin
      lane_d = lane_q;
      if (lane_cap[i]) lane_d = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign handler[i*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/vec_irq_fetch.sv
module vec_irq_fetch #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_req,
  output logic                irq_ack,
  input  logic                dev_valid,
  input  logic [BYTE_W-1:0]   dev_byte,
  input  logic                page_we,
  input  logic [BYTE_W-1:0]   page_wdata,
  output logic                mem_req,
  output logic [2*BYTE_W-1:0] mem_addr,
  input  logic                mem_ready,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                pc_load,
  output logic [2*BYTE_W-1:0] pc_value
);
  logic [BYTE_W-1:0] page_q;
  logic sel_hi, cap_ptr, cap_lo, cap_hi;

  vif_page_reg #(.BYTE_W(BYTE_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (page_we),
    .wr_data (page_wdata),
    .page_q  (page_q)
  );

  vif_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .dev_valid (dev_valid),
    .mem_ready (mem_ready),
    .irq_ack   (irq_ack),
    .mem_req   (mem_req),
    .sel_hi    (sel_hi),
    .cap_ptr   (cap_ptr),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .pc_load   (pc_load)
  );

  vif_addr_path #(.BYTE_W(BYTE_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_q    (page_q),
    .dev_byte  (dev_byte),
    .mem_rdata (mem_rdata),
    .cap_ptr   (cap_ptr),
    .lane_cap  ({cap_hi, cap_lo}),
    .sel_hi    (sel_hi),
    .mem_addr  (mem_addr),
    .handler   (pc_value)
  );
endmodule

// File: rtl/vif_checker.sv
module vif_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_req,
  input logic                irq_ack,
  input logic                dev_valid,
  input logic                mem_req,
  input logic [2*BYTE_W-1:0] mem_addr,
  input logic                mem_ready,
  input logic                pc_load
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!irq_ack && !mem_req && !pc_load));

  assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !dev_valid) |=> irq_ack);

  assert_lo_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !mem_addr[0]);

  assert_hi_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_addr[0]) |=>
      (mem_req && mem_addr == $past(mem_addr) + 1'b1));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !irq_ack);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, mem_req, pc_load}));
endmodule

bind vec_irq_fetch vif_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .dev_valid (dev_valid),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .pc_load   (pc_load)
);

// File: tb/vec_irq_fetch_tb.sv
module vec_irq_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        irq_ack;
  logic        dev_valid = 1'b0;
  logic [7:0]  dev_byte = 8'h00;
  logic        page_we = 1'b0;
  logic [7:0]  page_wdata = 8'h00;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        pc_load;
  logic [15:0] pc_value;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  int stall = 0;
  int dev_delay = 0;
  bit noise = 1'b0;
  logic [7:0] cur_byte = 8'h00;
  logic [7:0] cur_page = 8'h00;

  always #4 clk = ~clk;

  vec_irq_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .dev_valid(dev_valid), .dev_byte(dev_byte), .page_we(page_we),
    .page_wdata(page_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .pc_load(pc_load),
    .pc_value(pc_value)
  );

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Behavioural reference: phase 0 idle, 1 ack, 2 low read, 3 high read, 4 load
  int m_ph = 0;
  logic [7:0]  m_page = 8'h00;
  logic [15:0] m_ptr = 16'h0000;
  logic [7:0]  m_lo = 8'h00, m_hi = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_page = 8'h00;
    end else begin
      case (m_ph)
        0: if (irq_req) m_ph = 1;
        1: if (dev_valid) begin m_ptr = {m_page, dev_byte[7:1], 1'b0}; m_ph = 2; end
        2: if (mem_ready) begin m_lo = mem_rdata; m_ph = 3; end
        3: if (mem_ready) begin m_hi = mem_rdata; m_ph = 4; end
        default: m_ph = 0;
      endcase
      if (page_we) m_page = page_wdata;
    end
  end

  always @(negedge clk) begin
    chk(irq_ack === (m_ph == 1), "R2 irq_ack", int'(irq_ack), int'(m_ph == 1));
    chk(mem_req === (m_ph == 2 || m_ph == 3), "R5 mem_req", int'(mem_req), int'(m_ph == 2 || m_ph == 3));
    chk(pc_load === (m_ph == 4), "R6 pc_load", int'(pc_load), int'(m_ph == 4));
    if (m_ph == 2) chk(mem_addr === m_ptr, "R3 mem_addr", int'(mem_addr), int'(m_ptr));
    if (m_ph == 3) chk(mem_addr === (m_ptr | 16'h1), "R4 mem_addr", int'(mem_addr), int'(m_ptr | 16'h1));
    if (m_ph == 4) chk(pc_value === {m_hi, m_lo}, "R6 pc_value", int'(pc_value), int'({m_hi, m_lo}));
  end

  // Device and memory responder
  int wcnt = 0, dcnt = 0;
  always @(negedge clk) begin
    mem_rdata = memfn(mem_addr);
    if (mem_req) begin
      mem_ready = (wcnt >= stall);
      if (mem_ready) wcnt = 0; else wcnt++;
    end else begin
      mem_ready = noise; wcnt = 0;
    end
    if (irq_ack) begin
      dev_valid = (dcnt >= dev_delay);
      dev_byte = cur_byte;
      dcnt++;
    end else begin
      dev_valid = noise; dev_byte = 8'hAA; dcnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
      finish_run();
    end
  end

  task automatic run_irq(input logic [7:0] pg, input logic [7:0] vb, input int st,
                         input int dd, input bit hold, input bit midwr,
                         input logic [7:0] newpg, input string tag);
    logic [15:0] ptr;
    logic [15:0] exp_h;
    int acks = 0;
    bit last_ack = 1'b0;
    bit seen = 1'b0;
    bit wrote = 1'b0;
    logic [15:0] first_addr = 16'h0;
    if (pg != cur_page) begin
      page_we = 1'b1; page_wdata = pg;
      @(negedge clk);
      page_we = 1'b0; cur_page = pg;
    end
    stall = st; dev_delay = dd; cur_byte = vb;
    ptr = {pg, vb[7:1], 1'b0};
    exp_h = {memfn(ptr | 16'h1), memfn(ptr)};
    irq_req = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (!hold) irq_req = 1'b0;
      if (irq_ack && !last_ack) acks++;
      last_ack = irq_ack;
      page_we = 1'b0;
      if (mem_req && !seen) begin
        seen = 1'b1; first_addr = mem_addr;
        if (midwr && !wrote) begin page_we = 1'b1; page_wdata = newpg; wrote = 1'b1; end
      end
      if (pc_load) break;
    end
    irq_req = 1'b0;
    page_we = 1'b0;
    chk(pc_load === 1'b1 && pc_value === exp_h, {"R6 handler ", tag}, int'(pc_value), int'(exp_h));
    chk(first_addr === ptr, {"R3 table address ", tag}, int'(first_addr), int'(ptr));
    chk(acks == 1, {"R7 one acknowledge ", tag}, acks, 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!irq_ack && !pc_load, {"R7 idle after load ", tag}, int'({irq_ack, pc_load}), 0);
    end
    if (wrote) cur_page = newpg;
  endtask

  initial begin
    #1;
    chk(!irq_ack && !mem_req && !pc_load, "R1 reset outputs", int'({irq_ack, mem_req, pc_load}), 0);
    repeat (3) @(negedge clk);
    chk(!irq_ack && !mem_req && !pc_load, "R1 reset held", int'({irq_ack, mem_req, pc_load}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_irq(8'h12, 8'h35, 0, 0, 1'b0, 1'b0, 8'h00, "basic");
    run_irq(8'h12, 8'h80, 2, 3, 1'b0, 1'b0, 8'h00, "R5 stalls");
    run_irq(8'h40, 8'h07, 1, 1, 1'b1, 1'b0, 8'h00, "R7 held request");
    run_irq(8'h21, 8'h10, 1, 0, 1'b0, 1'b1, 8'h99, "R8 mid write");
    chk(cur_page == 8'h99, "R8 page tracking", int'(cur_page), 8'h99);
    run_irq(8'h99, 8'h02, 0, 0, 1'b0, 1'b0, 8'h00, "R8 new page");

    noise = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!irq_ack && !mem_req && !pc_load, "R9 idle noise", int'({irq_ack, mem_req, pc_load}), 0);
    end
    noise = 1'b0;
    @(negedge clk);

    run_irq(8'hFF, 8'hFF, 0, 0, 1'b0, 1'b0, 8'h00, "R4 top corner");
    run_irq(8'h00, 8'h00, 3, 2, 1'b0, 1'b0, 8'h00, "R3 zero corner");
    run_irq(8'h00, 8'h01, 0, 0, 1'b1, 1'b0, 8'h00, "R10 odd byte");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule